// File: doc/BRIEF.md
# Calendar Real-Time Clock with Selectable Encoding

This block keeps wall-clock time and a calendar. Each pulse on its one-second tick input moves seconds forward and carries through minutes, hours, day of week, day of month, month and a two-digit year. A host reads and writes the values through a small parallel register port. Control bits choose how every time and calendar value appears at that port: BCD or plain binary, and 12-hour or 24-hour hours with a PM flag. Internally the counters are kept in binary with 24-hour hours, so a change of mode takes effect at once and the time is kept.

A sequencer separates the tick from the counter update. It has four states. In S_IDLE it waits for a tick. A tick moves it to S_LEAD, where it holds for LEAD_CYC cycles while the update-in-progress flag is already raised. It then moves to S_STEP, the single cycle that advances the counters. Next comes S_END, which raises the update-ended flag and compares the alarm hour, then returns to S_IDLE. A tick that arrives outside S_IDLE is ignored. The update-ended flag can be passed to the interrupt output by an enable bit. The alarm flag sets on an hour match. Reading the flag register clears both flags.

Register offsets: 0 seconds, 1 minutes, 2 hours, 3 alarm hours, 4 day of week, 5 day of month, 6 month, 7 year, 8 status (read-only), 9 control, 10 flags (read clears).

Top module: `rtc_calendar`

## Requirements
- R1: After reset, seconds, minutes, hours, alarm hours and year read 0. Day of week, day of month and month read 1. Control reads 0x02 (24-hour, BCD). Status reads 0x20. irq is 0.
- R2: Each accepted tick adds one second. The carry passes 59→0 seconds, 59→0 minutes and 23→0 hours into the date. Day of week wraps 7→1 (1 = Sunday). Month wraps 12→1. Year wraps 99→0.
- R3: Day of month wraps to 1 after the last day of its month: 30 for months 4, 6, 9 and 11; 31 for the other months except February; 28 for February, or 29 when the year is divisible by 4.
- R4: Control bit 2 selects the data encoding for reads and writes of every time, calendar and alarm register: 0 is BCD (tens in bits 7:4, units in bits 3:0) and 1 is binary.
- R5: Control bit 1 selects the hour format: 1 is 24-hour (0–23) and 0 is 12-hour. In 12-hour form, bits 5:0 hold 12, 1..11 and bit 7 is set for PM. Going from 11 to 12 toggles PM, so 11 PM becomes 12 AM of the next day.
- R6: Changing control bits 1 and 2 does not change the kept time. Only the encoding of later reads changes.
- R7: Alarm hours use the hour encoding, with PM in bit 7 (12-hour only) and bit 6 reading 0. The alarm flag (flags bit 5) sets when, at the end of an update, the alarm hour equals the current hour.
- R8: Status bit 7 (update in progress) rises the cycle after a tick is accepted. The counters change LEAD_CYC+1 cycles after that. The bit clears one cycle after the change. Status bits 6:0 read 0x20.
- R9: The update-ended flag (flags bit 4) sets at the end of each update. irq and flags bit 7 are high exactly when that flag is set and control bit 4 is 1.
- R10: A read of the flag register returns the flags and then clears the update-ended and alarm flags.
- R11: Reserved bits read 0 and writes to them are ignored: day of week bits 7:3, control bits 7:5, 3 and 0, and writes to the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle pulse once per second |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| irq | output | 1 | Update-ended interrupt request |

## Verification
A corrupted counter or carry shows at the host port within one update. It reads back as a wrong field after the next tick, so the table of boundary vectors checks each rollover (year end, leap and short months, 11→12 in both halves of the day) one tick after loading. A sequencer stuck in the wrong state shows as a wrong status bit or a step on the wrong cycle. The bench samples on the exact cycles after the tick where the flag and the seconds should change. Encoding and flag faults show on the first read after a mode write or flag read.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef enum logic [1:0] {
        S_IDLE,
        S_LEAD,
        S_STEP,
        S_END
    } seq_state_t;

    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_SEC  = 4'd0;
    localparam logic [ADDR_W-1:0] A_MIN  = 4'd1;
    localparam logic [ADDR_W-1:0] A_HOUR = 4'd2;
    localparam logic [ADDR_W-1:0] A_ALM  = 4'd3;
    localparam logic [ADDR_W-1:0] A_DOW  = 4'd4;
    localparam logic [ADDR_W-1:0] A_DOM  = 4'd5;
    localparam logic [ADDR_W-1:0] A_MON  = 4'd6;
    localparam logic [ADDR_W-1:0] A_YEAR = 4'd7;
    localparam logic [ADDR_W-1:0] A_STAT = 4'd8;
    localparam logic [ADDR_W-1:0] A_CTRL = 4'd9;
    localparam logic [ADDR_W-1:0] A_FLAG = 4'd10;

    localparam logic [6:0] STAT_FIXED = 7'h20;

    // host byte -> binary value
    function automatic logic [6:0] code_in(input logic [7:0] b, input logic bin);
        if (bin)
            return b[6:0];
        return 7'(7'(b[7:4]) * 7'd10 + 7'(b[3:0]));
    endfunction

    // binary value -> host byte
    function automatic logic [7:0] code_out(input logic [6:0] v, input logic bin);
        if (bin)
            return {1'b0, v};
        return (8'(v / 7'd10) << 4) | 8'(v % 7'd10);
    endfunction

    function automatic logic [7:0] hour_out(input logic [4:0] h, input logic h24, input logic bin);
        logic [4:0] h12;
        logic [7:0] e;
        if (h24)
            return code_out(7'(h), bin);
        if (h == 5'd0)
            h12 = 5'd12;
        else if (h > 5'd12)
            h12 = h - 5'd12;
        else
            h12 = h;
        e = code_out(7'(h12), bin);
        return (e & 8'h3F) | {(h >= 5'd12), 7'b0};
    endfunction

    function automatic logic [4:0] hour_in(input logic [7:0] b, input logic h24, input logic bin);
        logic [6:0] v;
        v = code_in({2'b00, b[5:0]}, bin);
        if (h24)
            return v[4:0];
        if (v == 7'd12)
            v = 7'd0;
        return 5'(v) + (b[7] ? 5'd12 : 5'd0);
    endfunction

    function automatic logic [4:0] month_len(input logic [3:0] m, input logic leap);
        case (m)
            4'd2:                     return leap ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:  return 5'd30;
            default:                  return 5'd31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_seq_fsm.sv
module rtc_seq_fsm
    import rtc_pkg::*;
#(
    parameter int LEAD_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic uip,
    output logic step,
    output logic done
);

    localparam int CW = $clog2(LEAD_CYC + 1);

    seq_state_t      st, st_nx;
    logic [CW-1:0]   lead_cnt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= S_IDLE;
            lead_cnt <= '0;
        end else begin
            st       <= st_nx;
            lead_cnt <= (st == S_LEAD) ? lead_cnt + 1'b1 : '0;
        end
    end

    // transitions
    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE: if (tick) st_nx = S_LEAD;
            S_LEAD: if (lead_cnt == CW'(LEAD_CYC - 1)) st_nx = S_STEP;
            S_STEP: st_nx = S_END;
            S_END:  st_nx = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        uip  = 1'b1;
        step = 1'b0;
        done = 1'b0;
        unique case (st)
            S_IDLE: uip  = 1'b0;
            S_LEAD: ;
            S_STEP: step = 1'b1;
            S_END:  done = 1'b1;
        endcase
    end

endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic              h24,
    input  logic              bin,
    output logic [5:0]        sec_q,
    output logic [5:0]        min_q,
    output logic [4:0]        hour_q,
    output logic [4:0]        alm_q,
    output logic [2:0]        dow_q,
    output logic [4:0]        dom_q,
    output logic [3:0]        mon_q,
    output logic [6:0]        year_q
);

    logic [5:0] n_sec, n_min;
    logic [4:0] n_hour, n_dom;
    logic [2:0] n_dow;
    logic [3:0] n_mon;
    logic [6:0] n_year;
    logic       c_min, c_hour, c_day, c_mon, c_year;

    always_comb begin
        c_min  = (sec_q >= 6'd59);
        c_hour = c_min && (min_q >= 6'd59);
        c_day  = c_hour && (hour_q >= 5'd23);
        c_mon  = c_day && (dom_q >= month_len(mon_q, year_q[1:0] == 2'd0));
        c_year = c_mon && (mon_q >= 4'd12);

        n_sec  = c_min  ? 6'd0 : sec_q + 6'd1;
        n_min  = min_q;
        n_hour = hour_q;
        n_dow  = dow_q;
        n_dom  = dom_q;
        n_mon  = mon_q;
        n_year = year_q;
        if (c_min)  n_min  = (min_q >= 6'd59) ? 6'd0 : min_q + 6'd1;
        if (c_hour) n_hour = (hour_q >= 5'd23) ? 5'd0 : hour_q + 5'd1;
        if (c_day) begin
            n_dow = (dow_q >= 3'd7 || dow_q == 3'd0) ? 3'd1 : dow_q + 3'd1;
            n_dom = c_mon ? 5'd1 : dom_q + 5'd1;
        end
        if (c_mon)  n_mon  = c_year ? 4'd1 : mon_q + 4'd1;
        if (c_year) n_year = (year_q >= 7'd99) ? 7'd0 : year_q + 7'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_q  <= '0;
            min_q  <= '0;
            hour_q <= '0;
            alm_q  <= '0;
            dow_q  <= 3'd1;
            dom_q  <= 5'd1;
            mon_q  <= 4'd1;
            year_q <= '0;
        end else begin
            if (step) begin
                sec_q  <= n_sec;
                min_q  <= n_min;
                hour_q <= n_hour;
                dow_q  <= n_dow;
                dom_q  <= n_dom;
                mon_q  <= n_mon;
                year_q <= n_year;
            end
            // a host write in the same cycle wins over the step
            if (wr_en) begin
                case (waddr)
                    A_SEC:  sec_q  <= 6'(code_in({1'b0, wdata[6:0]}, bin));
                    A_MIN:  min_q  <= 6'(code_in({1'b0, wdata[6:0]}, bin));
                    A_HOUR: hour_q <= hour_in(wdata, h24, bin);
                    A_ALM:  alm_q  <= hour_in(wdata, h24, bin);
                    A_DOW:  dow_q  <= wdata[2:0];
                    A_DOM:  dom_q  <= 5'(code_in({2'b00, wdata[5:0]}, bin));
                    A_MON:  mon_q  <= 4'(code_in({3'b000, wdata[4:0]}, bin));
                    A_YEAR: year_q <= code_in(wdata, bin);
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/rtc_regs.sv
module rtc_regs
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        ctl_wbits,   // {enable, binary, 24h}
    input  logic              done,
    input  logic              alarm_hit,
    input  logic              uip,
    input  logic [5:0]        sec_q,
    input  logic [5:0]        min_q,
    input  logic [4:0]        hour_q,
    input  logic [4:0]        alm_q,
    input  logic [2:0]        dow_q,
    input  logic [4:0]        dom_q,
    input  logic [3:0]        mon_q,
    input  logic [6:0]        year_q,
    output logic [7:0]        rdata,
    output logic              h24,
    output logic              bin,
    output logic              uie,
    output logic              uf,
    output logic              af,
    output logic              rd_flags,
    output logic              irq
);

    assign rd_flags = sel && !wr && (addr == A_FLAG);
    assign irq      = uf && uie;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h24 <= 1'b1;
            bin <= 1'b0;
            uie <= 1'b0;
            uf  <= 1'b0;
            af  <= 1'b0;
        end else begin
            if (sel && wr && addr == A_CTRL) begin
                uie <= ctl_wbits[2];
                bin <= ctl_wbits[1];
                h24 <= ctl_wbits[0];
            end
            if (rd_flags) begin
                uf <= 1'b0;
                af <= 1'b0;
            end
            if (done) begin
                uf <= 1'b1;
                if (alarm_hit)
                    af <= 1'b1;
            end
        end
    end

    always_comb begin
        case (addr)
            A_SEC:   rdata = code_out(7'(sec_q), bin);
            A_MIN:   rdata = code_out(7'(min_q), bin);
            A_HOUR:  rdata = hour_out(hour_q, h24, bin);
            A_ALM:   rdata = hour_out(alm_q, h24, bin);
            A_DOW:   rdata = {5'b0, dow_q};
            A_DOM:   rdata = code_out(7'(dom_q), bin);
            A_MON:   rdata = code_out(7'(mon_q), bin) & 8'h1F;
            A_YEAR:  rdata = code_out(year_q, bin);
            A_STAT:  rdata = {uip, STAT_FIXED};
            A_CTRL:  rdata = {3'b000, uie, 1'b0, bin, h24, 1'b0};
            A_FLAG:  rdata = {irq, 1'b0, af, uf, 4'b0000};
            default: rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
#(
    parameter int LEAD_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              irq
);

    logic       uip, step, done;
    logic       h24, bin, uie, uf, af, rd_flags;
    logic       host_wr;
    logic [5:0] sec_q, min_q;
    logic [4:0] hour_q, alm_q, dom_q;
    logic [2:0] dow_q;
    logic [3:0] mon_q;
    logic [6:0] year_q;

    assign host_wr = bus_sel && bus_wr;

    rtc_seq_fsm #(.LEAD_CYC(LEAD_CYC)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .uip   (uip),
        .step  (step),
        .done  (done)
    );

    rtc_time_core u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (step),
        .wr_en  (host_wr),
        .waddr  (bus_addr),
        .wdata  (bus_wdata),
        .h24    (h24),
        .bin    (bin),
        .sec_q  (sec_q),
        .min_q  (min_q),
        .hour_q (hour_q),
        .alm_q  (alm_q),
        .dow_q  (dow_q),
        .dom_q  (dom_q),
        .mon_q  (mon_q),
        .year_q (year_q)
    );

    rtc_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (bus_sel),
        .wr        (bus_wr),
        .addr      (bus_addr),
        .ctl_wbits ({bus_wdata[4], bus_wdata[2], bus_wdata[1]}),
        .done      (done),
        .alarm_hit (alm_q == hour_q),
        .uip       (uip),
        .sec_q     (sec_q),
        .min_q     (min_q),
        .hour_q    (hour_q),
        .alm_q     (alm_q),
        .dow_q     (dow_q),
        .dom_q     (dom_q),
        .mon_q     (mon_q),
        .year_q    (year_q),
        .rdata     (bus_rdata),
        .h24       (h24),
        .bin       (bin),
        .uie       (uie),
        .uf        (uf),
        .af        (af),
        .rd_flags  (rd_flags),
        .irq       (irq)
    );

endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       uip,
    input logic       step,
    input logic       done,
    input logic       host_wr,
    input logic       uie,
    input logic       uf,
    input logic       rd_flags,
    input logic       irq,
    input logic [5:0] sec_q,
    input logic [2:0] dow_q
);

    // R8: a tick seen while idle raises the busy flag next cycle
    a_r8_uip_follows_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !uip) |=> uip);

    // R8: with no update running and no write, the seconds hold
    a_r8_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!uip && !host_wr) |=> $stable(sec_q));

    // R2: a step leaves seconds in range
    a_r2_sec_range: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !host_wr) |=> (sec_q < 6'd60));

    // R2: a step leaves day of week in 1..7
    a_r2_dow_range: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !host_wr) |=> (dow_q != 3'd0));

    // R9: end of update with enable set drives the request
    a_r9_irq_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        (done && uie) |=> irq);

    // R10: a flag read clears the update-ended flag
    a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_flags && !done) |=> !uf);

endmodule

bind rtc_calendar rtc_calendar_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .uip      (uip),
    .step     (step),
    .done     (done),
    .host_wr  (host_wr),
    .uie      (uie),
    .uf       (uf),
    .rd_flags (rd_flags),
    .irq      (irq),
    .sec_q    (sec_q),
    .dow_q    (dow_q)
);

// File: tb/rtc_calendar_test.sv
module rtc_calendar_test;

    localparam int LEAD = 4;
    localparam int NV   = 9;

    // ctrl, sec, min, hour, dow, dom, mon, year, then expected
    // sec, min, hour, dow, dom, mon, year, then requirement number
    localparam logic [7:0] VEC [NV][16] = '{
        '{8'h02, 8'h59,8'h59,8'h23,8'h07,8'h31,8'h12,8'h99, 8'h00,8'h00,8'h00,8'h01,8'h01,8'h01,8'h00, 8'd2}, // R2 year end
        '{8'h02, 8'h59,8'h59,8'h23,8'h03,8'h28,8'h02,8'h24, 8'h00,8'h00,8'h00,8'h04,8'h29,8'h02,8'h24, 8'd3}, // R3 leap Feb
        '{8'h02, 8'h59,8'h59,8'h23,8'h02,8'h28,8'h02,8'h23, 8'h00,8'h00,8'h00,8'h03,8'h01,8'h03,8'h23, 8'd3}, // R3 common Feb
        '{8'h02, 8'h59,8'h59,8'h23,8'h07,8'h30,8'h04,8'h50, 8'h00,8'h00,8'h00,8'h01,8'h01,8'h05,8'h50, 8'd3}, // R3 30-day month
        '{8'h06, 8'h3B,8'h3B,8'h17,8'h05,8'h1D,8'h02,8'h18, 8'h00,8'h00,8'h00,8'h06,8'h01,8'h03,8'h18, 8'd4}, // R4 binary
        '{8'h00, 8'h59,8'h59,8'h11,8'h02,8'h15,8'h06,8'h10, 8'h00,8'h00,8'h92,8'h02,8'h15,8'h06,8'h10, 8'd5}, // R5 11AM->12PM
        '{8'h00, 8'h59,8'h59,8'h91,8'h02,8'h15,8'h06,8'h10, 8'h00,8'h00,8'h12,8'h03,8'h16,8'h06,8'h10, 8'd5}, // R5 11PM->12AM
        '{8'h02, 8'h56,8'h34,8'h12,8'h01,8'h10,8'h10,8'h50, 8'h57,8'h34,8'h12,8'h01,8'h10,8'h10,8'h50, 8'd2}, // R2 no carry
        '{8'h04, 8'h3B,8'h3B,8'h8C,8'h01,8'h01,8'h01,8'h00, 8'h00,8'h00,8'h81,8'h01,8'h01,8'h01,8'h00, 8'd5}  // R5 12PM->1PM binary
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    rtc_calendar #(.LEAD_CYC(LEAD)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic do_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        repeat (LEAD + 4) @(negedge clk);
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [7:0] exp, input string req);
        logic [7:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got 0x00 expected 0x01");
        $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_chk(4'd0,  8'h00, "R1 sec");
        rd_chk(4'd2,  8'h00, "R1 hour");
        rd_chk(4'd3,  8'h00, "R1 alarm");
        rd_chk(4'd4,  8'h01, "R1 dow");
        rd_chk(4'd5,  8'h01, "R1 dom");
        rd_chk(4'd6,  8'h01, "R1 month");
        rd_chk(4'd7,  8'h00, "R1 year");
        rd_chk(4'd9,  8'h02, "R1 control");
        rd_chk(4'd8,  8'h20, "R1 status");
        chk("R1 irq", {7'b0, irq}, 8'h00);

        // vector table
        for (int i = 0; i < NV; i++) begin
            wr(4'd9, VEC[i][0]);
            for (int k = 0; k < 7; k++)
                wr((k < 3) ? 4'(k) : 4'(k + 1), VEC[i][k + 1]);
            do_tick();
            for (int k = 0; k < 7; k++) begin
                rd((k < 3) ? 4'(k) : 4'(k + 1), d);
                chk($sformatf("R%0d vec%0d field%0d", VEC[i][15], i, k), d, VEC[i][k + 8]);
            end
        end

        // R11 reserved bits
        wr(4'd4, 8'hF3);
        rd_chk(4'd4, 8'h03, "R11 dow reserved");
        wr(4'd9, 8'hFF);
        rd_chk(4'd9, 8'h16, "R11 control reserved");
        wr(4'd8, 8'h00);
        rd_chk(4'd8, 8'h20, "R11 status write ignored");
        wr(4'd9, 8'h02);

        // R6 mode switch keeps time
        wr(4'd2, 8'h15);
        wr(4'd9, 8'h00);
        rd_chk(4'd2, 8'h83, "R6 12h BCD");
        wr(4'd9, 8'h04);
        rd_chk(4'd2, 8'h83, "R6 12h binary");
        wr(4'd9, 8'h06);
        rd_chk(4'd2, 8'h0F, "R6 24h binary");
        wr(4'd9, 8'h02);
        rd_chk(4'd2, 8'h15, "R6 24h BCD");

        // R7 alarm match, R10 read clears
        wr(4'd9, 8'h00);
        wr(4'd3, 8'hC7);
        rd_chk(4'd3, 8'h87, "R7 alarm bit6 reads 0");
        wr(4'd2, 8'h86);
        wr(4'd1, 8'h59);
        wr(4'd0, 8'h59);
        rd(4'd10, d);
        do_tick();
        rd_chk(4'd10, 8'h30, "R7 alarm hit");
        rd_chk(4'd10, 8'h00, "R10 flags cleared");
        wr(4'd3, 8'h08);
        do_tick();
        rd_chk(4'd10, 8'h10, "R7 no alarm on mismatch");

        // R9 interrupt gating
        wr(4'd9, 8'h12);
        rd(4'd10, d);
        chk("R9 irq idle", {7'b0, irq}, 8'h00);
        do_tick();
        chk("R9 irq raised", {7'b0, irq}, 8'h01);
        rd_chk(4'd10, 8'h90, "R9 flags with irq");
        chk("R10 irq cleared", {7'b0, irq}, 8'h00);
        wr(4'd9, 8'h02);

        // R8 update-in-progress timing
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 4'd8; tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        #1 chk("R8 uip after tick", bus_rdata, 8'hA0);
        repeat (LEAD + 1) @(negedge clk);
        #1 chk("R8 uip at update end", bus_rdata, 8'hA0);
        @(negedge clk);
        #1 chk("R8 uip cleared", bus_rdata, 8'h20);
        bus_sel = 1'b0;
        repeat (2) @(negedge clk);

        wr(4'd0, 8'h10);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 4'd0; tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        repeat (LEAD) @(negedge clk);
        #1 chk("R8 seconds before step", bus_rdata, 8'h10);
        @(negedge clk);
        #1 chk("R8 seconds after step", bus_rdata, 8'h11);
        bus_sel = 1'b0;
        repeat (4) @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule